// File: doc/BRIEF.md
# Partitioned Pattern Sequencer

This block steps a self-test through a set of independent pattern sources, one per slice of the circuit under test, and routes exactly one of them onto a shared scan input at a time. It holds a single pattern counter split into two fields. The low field is a pattern number that goes to every source. The high field picks which source drives the scan chain. Each source therefore runs for a full block of 2^PAT_BITS patterns before the next one takes over. The sources never interleave, and a whole test lasts NUM_GEN·2^PAT_BITS patterns.

A test begins with a one-cycle `start` pulse. The surrounding controller then pulses `advance` once after each pattern has been shifted in. After the last pattern of the last source, the block raises `done` and freezes the counter. It stays frozen until the next `start`. All sources can be built around one shared shift-register generator, so that moving from one source to the next only changes which bit-modification logic is selected.

Top module: `bist_seq`

## Requirements
- R1: After reset, `pat_idx` and `gen_sel` are zero, `done` is 0 and `scan_out` is 0.
- R2: A cycle with `start` high clears both counter fields to zero and clears `done` at the next clock edge. From then on the block is running.
- R3: While running, a cycle with `advance` high increments the counter `{gen_sel, pat_idx}` by exactly one at the next edge. A running cycle without `advance` leaves the counter unchanged.
- R4: `pat_idx` is the low PAT_BITS bits of the counter and `gen_sel` is the high bits. When `pat_idx` wraps from all ones to zero, `gen_sel` goes up by one.
- R5: While running, `scan_out` equals `gen_bits[gen_sel]` in the same cycle, with bit i carrying source i. While not running, `scan_out` is 0.
- R6: The advance taken at count NUM_GEN·2^PAT_BITS−1 raises `done` at the next edge. The counter then holds at `gen_sel`=NUM_GEN−1 with `pat_idx` all ones. `gen_sel` never takes a value of NUM_GEN or above.
- R7: While the block is not running (after reset or after `done`), `advance` has no effect on the counter, on `done` or on `scan_out`.
- R8: `start` restarts a test that is already running at count zero. When `start` and `advance` are high in the same cycle, the counter still ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin or restart a test |
| advance | input | 1 | One pulse per completed pattern |
| gen_bits | input | NUM_GEN | Serial data from each pattern source |
| scan_out | output | 1 | Selected serial data to the scan chain |
| pat_idx | output | PAT_BITS | Pattern number sent to every source |
| gen_sel | output | SEL_BITS | Index of the active source |
| done | output | 1 | Test finished |

## Verification
`pat_idx`, `gen_sel` and `done` are registered. Each one shows the effect of a `start` or `advance` one edge after the cycle in which that input is high. `scan_out` is combinational, so it follows a change in `gen_bits` within the same cycle. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. At that point it compares the registered outputs with a reference model that it updated for that edge. It also compares `scan_out` against the source bit picked by the model, using the `gen_bits` value that is being applied at that moment.

// File: rtl/bist_seq.sv
module bist_seq #(
  parameter int NUM_GEN  = 3,
  parameter int PAT_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                advance,
  input  logic [NUM_GEN-1:0]  gen_bits,
  output logic                scan_out,
  output logic [PAT_BITS-1:0] pat_idx,
  output logic [((NUM_GEN > 1) ? $clog2(NUM_GEN) : 1)-1:0] gen_sel,
  output logic                done
);
  localparam int SEL_BITS = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
  localparam int CW       = PAT_BITS + SEL_BITS;
  localparam logic [CW-1:0] LAST = CW'(NUM_GEN * (2 ** PAT_BITS) - 1);

  logic [CW-1:0] cnt;
  logic          running;
  logic          at_last;

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (running && advance) begin
      if (at_last) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pat_idx  = cnt[PAT_BITS-1:0];
  assign gen_sel  = cnt[CW-1:PAT_BITS];
  assign scan_out = running & gen_bits[gen_sel];
endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
  parameter int NUM_GEN  = 3,
  parameter int PAT_BITS = 4,
  parameter int SEL_BITS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                advance,
  input logic                running,
  input logic                done,
  input logic [PAT_BITS-1:0] pat_idx,
  input logic [SEL_BITS-1:0] gen_sel
);
  localparam int CW = PAT_BITS + SEL_BITS;
  localparam logic [CW-1:0] LAST = CW'(NUM_GEN * (2 ** PAT_BITS) - 1);
  logic [CW-1:0] cnt;
  assign cnt = {gen_sel, pat_idx};

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0) && !done);

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (running && advance && !start && cnt != LAST) |=> cnt == CW'($past(cnt) + 1'b1));

  a_r3_hold_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !advance && !start) |=> $stable(cnt));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gen_sel) < NUM_GEN);

  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (running && advance && !start && cnt == LAST) |=> done && cnt == LAST);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(cnt) && $stable(done));
endmodule

bind bist_seq bist_seq_chk #(
  .NUM_GEN(NUM_GEN), .PAT_BITS(PAT_BITS), .SEL_BITS(SEL_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
  .running(running), .done(done), .pat_idx(pat_idx), .gen_sel(gen_sel)
);

// File: tb/bist_seq_test.sv
module bist_seq_test;
  localparam int NG = 3;
  localparam int PB = 4;
  localparam int SB = 2;
  localparam int TOTAL = NG * (2 ** PB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic advance = 1'b0;
  logic [NG-1:0] gen_bits = '0;
  logic scan_out;
  logic [PB-1:0] pat_idx;
  logic [SB-1:0] gen_sel;
  logic done;

  int errors = 0;
  int checks = 0;
  int m_cnt = 0;
  bit m_run = 0;
  bit m_done = 0;
  int unsigned seed = 32'h5eed;

  always #2.5 clk = ~clk;

  bist_seq #(.NUM_GEN(NG), .PAT_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .gen_bits(gen_bits), .scan_out(scan_out), .pat_idx(pat_idx),
    .gen_sel(gen_sel), .done(done)
  );

  function automatic bit exp_scan(int c, bit r, logic [NG-1:0] g);
    return r ? g[c / (2 ** PB)] : 1'b0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " pat_idx"}, int'(pat_idx), m_cnt % (2 ** PB));
    chk({req, " gen_sel"}, int'(gen_sel), m_cnt / (2 ** PB));
    chk({req, " done"}, int'(done), int'(m_done));
    chk({req, " scan_out"}, int'(scan_out), int'(exp_scan(m_cnt, m_run, gen_bits)));
  endtask

  task automatic step(bit s, bit a, string req);
    @(negedge clk);
    start = s; advance = a;
    gen_bits = NG'($urandom(seed));
    seed = seed + 1;
    @(posedge clk);
    if (s) begin m_cnt = 0; m_run = 1; m_done = 0; end
    else if (a && m_run) begin
      if (m_cnt == TOTAL - 1) begin m_run = 0; m_done = 1; end
      else m_cnt++;
    end
    #1;
    check_all(req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12;
    check_all("R1 reset");
    rst_n = 1'b1;
    step(0, 1, "R7 advance before start");
    step(0, 0, "R1 idle");
    step(1, 0, "R2 start");
    for (int i = 0; i < 40; i++) step(0, 1, "R3 R4 R5 advance");
    for (int i = 0; i < 20; i++) step(0, 0, "R3 hold");
    step(1, 1, "R8 start with advance");
    while (!m_done) step(0, 1'($urandom(seed) % 3 != 0), "R4 R5 R6 run");
    chk("R6 final gen_sel", int'(gen_sel), NG - 1);
    chk("R6 final pat_idx", int'(pat_idx), 2 ** PB - 1);
    for (int i = 0; i < 8; i++) step(0, 1, "R7 advance after done");
    step(1, 0, "R2 restart after done");
    for (int i = 0; i < 25; i++) step(0, 1, "R3 second run");
    step(1, 0, "R8 restart mid run");
    for (int i = 0; i < 6; i++) step(0, 1, "R4 after restart");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule